// File: doc/BRIEF.md
# Prioritized Trap Request Arbiter

This block sits at the exception-commit point of a processor pipeline. In one cycle any number of trap sources may be pending, one bit per source on a request vector. The arbiter picks exactly one of them, reports its 9-bit trap type code, and tells the trap logic which privilege mode the handler must run in. Every request line has a fixed rank number and a fixed base code. The rank decides the winner: a smaller number wins. Equal ranks are broken by the lower type code.

Four classes of line build their type code from a base plus a small index supplied with the request:
- the external interrupt line adds the interrupt level;
- the four register-window spill and fill lines add a window index;
- the software trap line adds the trap number.

The handler mode comes from a three-column table kept for each line. The column is chosen by the current execution level (user, privileged or hyperprivileged). A table entry is privileged, hyper, or "supervisor-or-hyper". The last one becomes hyper only when the processor already runs hyperprivileged.

The selection logic is purely combinational. A parameter adds one output register stage, which is on by default.

Top module: `trap_arbiter`

## Requirements
- R1: With no request bit set, `trap_valid` is 0, `trap_type` is 0 and `trap_hmode` is 0.
- R2: Among pending requests, the one with the smallest rank number is reported.
- R3: Among pending requests with the same smallest rank, the one with the lowest type code is reported.
- R4: The request bits carry these entries, written bit:code/rank:
  - bit 0: 0x001/0
  - bit 1: 0x002/120
  - bit 2: 0x005/1
  - bit 3: 0x010/620
  - bit 4: 0x011/700
  - bit 5: 0x020/800
  - bit 6: 0x021/1110
  - bit 7: 0x022/1110
  - bit 8: 0x028/1500
  - bit 9: 0x034/1020
  - bit 10: 0x037/1110
  - bit 11: 0x040+lvl/1600
  - bit 12: 0x080+win/900
  - bit 13: 0x0A0+win/900
  - bit 14: 0x0C0+win/900
  - bit 15: 0x0E0+win/900
  - bit 16: 0x100+num/1602
- R5: The code of bit 11 is 0x040 plus `int_lvl`. The codes of bits 12 to 15 are their base plus `win_idx`. The code of bit 16 is 0x100 plus `sw_num`.
- R6: `trap_hmode` is 1 for a privileged handler and 2 for a hyper handler. The mode table is given per request bit as columns user/privileged/hyper, with H = hyper, P = privileged and S = supervisor-or-hyper:
  - bits 0, 1, 2, 3 and 9: H/H/H
  - bit 4: P/S/S
  - bits 5 to 8 and 12 to 16: P/P/H
  - bit 10: H/H/S
  - bit 11: P/P/S
- R7: `exec_level` is encoded 0 = user, 1 = privileged, 2 = hyper, and 3 is treated as 2. An S entry yields mode 2 at level 2 or 3, and mode 1 otherwise.
- R8: With `OUT_REG`=1, the outputs show the selection for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R9: An index input belonging to a line that is not requested has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | 17 | Pending trap requests, one bit per line |
| exec_level | input | 2 | Current execution level |
| int_lvl | input | 4 | Interrupt level for bit 11 |
| win_idx | input | 5 | Window index for bits 12 to 15 |
| sw_num | input | 7 | Software trap number for bit 16 |
| trap_valid | output | 1 | A trap was selected |
| trap_type | output | 9 | Type code of the selected trap |
| trap_hmode | output | 2 | Handler privilege mode (1 privileged, 2 hyper) |

## Verification
The block holds no state beyond the output stage, so a wrong internal choice shows up at the ports on the very next clock edge. It appears either as a lower-ranked code winning or as the wrong handler mode for a given execution level. Tie cases are the sensitive spots: the three rank-1110 lines, the four rank-900 window lines sharing one index, and the supervisor-or-hyper entries at every level. A fault in the reduction tree or in the index addition changes `trap_type` in the cycle after the offending request pattern.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

  localparam int NUM_LINES = 17;
  localparam int TYPE_W    = 9;
  localparam int RANK_W    = 11;
  localparam int KEY_W     = RANK_W + TYPE_W;
  localparam int INT_W     = 4;
  localparam int WIN_W     = 5;
  localparam int SWN_W     = 7;

  typedef enum logic [1:0] {HM_NONE = 2'd0, HM_PRIV = 2'd1, HM_HYPER = 2'd2} hmode_e;
  typedef enum logic [1:0] {ME_PRIV = 2'd0, ME_SUPHYP = 2'd1, ME_HYP = 2'd2} mentry_e;
  typedef enum logic [1:0] {LV_USER = 2'd0, LV_PRIV = 2'd1, LV_HYPER = 2'd2, LV_RSVD = 2'd3} level_e;
  typedef enum logic [1:0] {IX_NONE = 2'd0, IX_INT = 2'd1, IX_WIN = 2'd2, IX_SWT = 2'd3} ixsrc_e;

  typedef struct packed {
    logic [TYPE_W-1:0] base;
    logic [RANK_W-1:0] rank;
    ixsrc_e            ix;
    mentry_e           m_user;
    mentry_e           m_priv;
    mentry_e           m_hyp;
  } line_desc_t;

  function automatic line_desc_t mk(input int b, input int r, input ixsrc_e ix,
                                    input mentry_e u, input mentry_e p, input mentry_e h);
    line_desc_t d;
    d.base   = TYPE_W'(b);
    d.rank   = RANK_W'(r);
    d.ix     = ix;
    d.m_user = u;
    d.m_priv = p;
    d.m_hyp  = h;
    return d;
  endfunction

  // Fixed descriptor of each request line; bit position is the line number.
  function automatic line_desc_t line_desc(input int i);
    case (i)
      0:  return mk('h001,    0, IX_NONE, ME_HYP,  ME_HYP,    ME_HYP);
      1:  return mk('h002,  120, IX_NONE, ME_HYP,  ME_HYP,    ME_HYP);
      2:  return mk('h005,    1, IX_NONE, ME_HYP,  ME_HYP,    ME_HYP);
      3:  return mk('h010,  620, IX_NONE, ME_HYP,  ME_HYP,    ME_HYP);
      4:  return mk('h011,  700, IX_NONE, ME_PRIV, ME_SUPHYP, ME_SUPHYP);
      5:  return mk('h020,  800, IX_NONE, ME_PRIV, ME_PRIV,   ME_HYP);
      6:  return mk('h021, 1110, IX_NONE, ME_PRIV, ME_PRIV,   ME_HYP);
      7:  return mk('h022, 1110, IX_NONE, ME_PRIV, ME_PRIV,   ME_HYP);
      8:  return mk('h028, 1500, IX_NONE, ME_PRIV, ME_PRIV,   ME_HYP);
      9:  return mk('h034, 1020, IX_NONE, ME_HYP,  ME_HYP,    ME_HYP);
      10: return mk('h037, 1110, IX_NONE, ME_HYP,  ME_HYP,    ME_SUPHYP);
      11: return mk('h040, 1600, IX_INT,  ME_PRIV, ME_PRIV,   ME_SUPHYP);
      12: return mk('h080,  900, IX_WIN,  ME_PRIV, ME_PRIV,   ME_HYP);
      13: return mk('h0A0,  900, IX_WIN,  ME_PRIV, ME_PRIV,   ME_HYP);
      14: return mk('h0C0,  900, IX_WIN,  ME_PRIV, ME_PRIV,   ME_HYP);
      15: return mk('h0E0,  900, IX_WIN,  ME_PRIV, ME_PRIV,   ME_HYP);
      16: return mk('h100, 1602, IX_SWT,  ME_PRIV, ME_PRIV,   ME_HYP);
      default: return mk(0, (1 << RANK_W) - 1, IX_NONE, ME_HYP, ME_HYP, ME_HYP);
    endcase
  endfunction

  // Type code = base plus the index that belongs to the line's class.
  function automatic logic [TYPE_W-1:0] form_code(input logic [TYPE_W-1:0] base,
                                                  input ixsrc_e ix,
                                                  input logic [INT_W-1:0] lvl,
                                                  input logic [WIN_W-1:0] win,
                                                  input logic [SWN_W-1:0] num);
    case (ix)
      IX_INT:  return base + TYPE_W'(lvl);
      IX_WIN:  return base + TYPE_W'(win);
      IX_SWT:  return base + TYPE_W'(num);
      default: return base;
    endcase
  endfunction

  // Ordering key: rank in the upper bits, code below; smaller key wins.
  function automatic logic [KEY_W-1:0] rank_key(input logic [RANK_W-1:0] r,
                                                input logic [TYPE_W-1:0] c);
    return {r, c};
  endfunction

  function automatic mentry_e pick_column(input line_desc_t d, input level_e lv);
    case (lv)
      LV_USER: return d.m_user;
      LV_PRIV: return d.m_priv;
      default: return d.m_hyp;
    endcase
  endfunction

  function automatic hmode_e resolve_mode(input mentry_e e, input level_e lv);
    case (e)
      ME_PRIV:   return HM_PRIV;
      ME_HYP:    return HM_HYPER;
      ME_SUPHYP: return (lv == LV_HYPER || lv == LV_RSVD) ? HM_HYPER : HM_PRIV;
      default:   return HM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/trap_code_gen.sv
module trap_code_gen
  import trap_arb_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic [INT_W-1:0]           int_lvl,
  input  logic [WIN_W-1:0]           win_idx,
  input  logic [SWN_W-1:0]           sw_num,
  output logic [N-1:0][TYPE_W-1:0]   codes,
  output logic [N-1:0][KEY_W-1:0]    keys
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam line_desc_t D = line_desc(i);
    assign codes[i] = form_code(D.base, D.ix, int_lvl, win_idx, sw_num);
    assign keys[i]  = rank_key(D.rank, codes[i]);
  end
endmodule

// File: rtl/trap_rank_tree.sv
module trap_rank_tree
  import trap_arb_pkg::*;
#(
  parameter int N = NUM_LINES,
  parameter int KW = KEY_W,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int LEAVES = 1 << IDX_W,
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic [N-1:0]          req,
  input  logic [N-1:0][KW-1:0]  keys,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_line
);
  logic [NODES-1:0] nv;
  logic [KW-1:0]    nk [NODES];
  logic [IDX_W-1:0] ni [NODES];

  always_comb begin
    for (int l = 0; l < LEAVES; l++) begin
      if (l < N) begin
        nv[LEAVES-1+l] = req[l];
        nk[LEAVES-1+l] = keys[l];
      end else begin
        nv[LEAVES-1+l] = 1'b0;
        nk[LEAVES-1+l] = '1;
      end
      ni[LEAVES-1+l] = IDX_W'(l);
    end
    for (int j = LEAVES - 2; j >= 0; j--) begin
      if (nv[2*j+1] && (!nv[2*j+2] || nk[2*j+1] <= nk[2*j+2])) begin
        nv[j] = 1'b1;
        nk[j] = nk[2*j+1];
        ni[j] = ni[2*j+1];
      end else begin
        nv[j] = nv[2*j+2];
        nk[j] = nk[2*j+2];
        ni[j] = ni[2*j+2];
      end
    end
  end

  assign win_valid = nv[0];
  assign win_line  = ni[0];
endmodule

// File: rtl/trap_mode_sel.sv
module trap_mode_sel
  import trap_arb_pkg::*;
#(
  parameter int N = NUM_LINES,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0] line,
  input  level_e           level,
  output hmode_e           hmode
);
  hmode_e per_line [N];

  for (genvar i = 0; i < N; i++) begin : g_mode
    localparam line_desc_t D = line_desc(i);
    assign per_line[i] = resolve_mode(pick_column(D, level), level);
  end

  always_comb begin
    hmode = HM_NONE;
    for (int i = 0; i < N; i++)
      if (line == IDX_W'(i)) hmode = per_line[i];
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int N       = NUM_LINES,
  parameter bit OUT_REG = 1'b1,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_vec,
  input  logic [1:0]        exec_level,
  input  logic [INT_W-1:0]  int_lvl,
  input  logic [WIN_W-1:0]  win_idx,
  input  logic [SWN_W-1:0]  sw_num,
  output logic              trap_valid,
  output logic [TYPE_W-1:0] trap_type,
  output logic [1:0]        trap_hmode
);
  logic [N-1:0][TYPE_W-1:0] codes;
  logic [N-1:0][KEY_W-1:0]  keys;
  logic                     c_valid;
  logic [IDX_W-1:0]         c_line;
  hmode_e                   c_mode_raw;
  logic [TYPE_W-1:0]        c_type;
  logic [1:0]               c_mode;
  level_e                   lvl;

  assign lvl = level_e'(exec_level);

  trap_code_gen #(.N(N)) u_codes (
    .int_lvl (int_lvl),
    .win_idx (win_idx),
    .sw_num  (sw_num),
    .codes   (codes),
    .keys    (keys)
  );

  trap_rank_tree #(.N(N), .KW(KEY_W)) u_tree (
    .req       (req_vec),
    .keys      (keys),
    .win_valid (c_valid),
    .win_line  (c_line)
  );

  trap_mode_sel #(.N(N)) u_mode (
    .line  (c_line),
    .level (lvl),
    .hmode (c_mode_raw)
  );

  always_comb begin
    c_type = '0;
    for (int i = 0; i < N; i++)
      if (c_line == IDX_W'(i)) c_type = codes[i];
    if (!c_valid) c_type = '0;
  end
  assign c_mode = c_valid ? c_mode_raw : HM_NONE;

  if (OUT_REG) begin : g_reg
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trap_valid <= 1'b0;
        trap_type  <= '0;
        trap_hmode <= '0;
        primed     <= 1'b0;
      end else begin
        trap_valid <= c_valid;
        trap_type  <= c_type;
        trap_hmode <= c_mode;
        primed     <= 1'b1;
      end
    end

    p_stage_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (trap_valid == $past(c_valid) && trap_type == $past(c_type)));
  end else begin : g_comb
    assign trap_valid = c_valid;
    assign trap_type  = c_type;
    assign trap_hmode = c_mode;
  end

  // Checker-side view: is some other pending line strictly better than the pick?
  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int i = 0; i < N; i++)
      if (req_vec[i] && c_line != IDX_W'(i) && keys[i] < keys[c_line]) beaten = 1'b1;
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_type == '0 && trap_hmode == 2'd0));

  p_valid_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid == (|req_vec));

  p_pick_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> req_vec[c_line]);

  p_no_better_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> !beaten);

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_hmode == 2'd1 || trap_hmode == 2'd2));

  p_user_no_suphyp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && lvl == LV_USER && c_line == IDX_W'(4)) |-> c_mode == 2'd1);
endmodule

// File: tb/trap_arbiter_tb.sv
module trap_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NL-1:0] req_vec = '0;
  logic [1:0]  exec_level = 2'd0;
  logic [3:0]  int_lvl = '0;
  logic [4:0]  win_idx = '0;
  logic [6:0]  sw_num = '0;
  logic        trap_valid;
  logic [8:0]  trap_type;
  logic [1:0]  trap_hmode;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int    bcode [NL];
  int    brank [NL];
  int    bkind [NL];   // 0 none, 1 level, 2 window, 3 trap number
  string mtab  [NL];   // user/priv/hyper column letters

  int prev_v = 0, prev_t = 0, prev_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .exec_level(exec_level),
    .int_lvl(int_lvl), .win_idx(win_idx), .sw_num(sw_num),
    .trap_valid(trap_valid), .trap_type(trap_type), .trap_hmode(trap_hmode)
  );

  task automatic set_line(input int i, input int c, input int r, input int k, input string m);
    bcode[i] = c; brank[i] = r; bkind[i] = k; mtab[i] = m;
  endtask

  task automatic model(output int v, output int t, output int m);
    int best;
    best = -1; v = 0; t = 0; m = 0;
    for (int i = 0; i < NL; i++) begin
      if (req_vec[i]) begin
        int c;
        c = bcode[i];
        if (bkind[i] == 1) c += int_lvl;
        if (bkind[i] == 2) c += win_idx;
        if (bkind[i] == 3) c += sw_num;
        if (best < 0 || brank[i] < brank[best] ||
            (brank[i] == brank[best] && c < t)) begin
          best = i; t = c;
        end
      end
    end
    if (best >= 0) begin
      int col;
      byte e;
      v = 1;
      col = (exec_level >= 2) ? 2 : int'(exec_level);
      e = mtab[best][col];
      if (e == "H") m = 2;
      else if (e == "P") m = 1;
      else m = (exec_level >= 2) ? 2 : 1;
    end
  endtask

  task automatic check(input string tag, input int v, input int t, input int m);
    n_checks++;
    if (int'(trap_valid) != v || int'(trap_type) != t || int'(trap_hmode) != m) begin
      n_fail++;
      $display("FAIL %s: got valid=%0d type=0x%03h mode=%0d, expected valid=%0d type=0x%03h mode=%0d",
               tag, trap_valid, trap_type, trap_hmode, v, t, m);
    end
  endtask

  // Drive at falling edge; outputs must hold the old result until the next
  // rising edge (R8), then show the new one.
  task automatic step(input logic [NL-1:0] r, input int lv, input int il,
                      input int wi, input int sn, input string tag);
    int v, t, m;
    @(negedge clk);
    req_vec = r; exec_level = 2'(lv); int_lvl = 4'(il); win_idx = 5'(wi); sw_num = 7'(sn);
    #1;
    check({"R8 hold / ", tag}, prev_v, prev_t, prev_m);
    model(v, t, m);
    @(posedge clk);
    #1;
    check(tag, v, t, m);
    prev_v = v; prev_t = t; prev_m = m;
  endtask

  initial begin
    set_line(0,  'h001,    0, 0, "HHH");
    set_line(1,  'h002,  120, 0, "HHH");
    set_line(2,  'h005,    1, 0, "HHH");
    set_line(3,  'h010,  620, 0, "HHH");
    set_line(4,  'h011,  700, 0, "PSS");
    set_line(5,  'h020,  800, 0, "PPH");
    set_line(6,  'h021, 1110, 0, "PPH");
    set_line(7,  'h022, 1110, 0, "PPH");
    set_line(8,  'h028, 1500, 0, "PPH");
    set_line(9,  'h034, 1020, 0, "HHH");
    set_line(10, 'h037, 1110, 0, "HHS");
    set_line(11, 'h040, 1600, 1, "PPS");
    set_line(12, 'h080,  900, 2, "PPH");
    set_line(13, 'h0A0,  900, 2, "PPH");
    set_line(14, 'h0C0,  900, 2, "PPH");
    set_line(15, 'h0E0,  900, 2, "PPH");
    set_line(16, 'h100, 1602, 3, "PPH");

    // R8: reset clears outputs even with requests pending
    req_vec = '1;
    repeat (3) @(posedge clk);
    #1 check("R8 reset", 0, 0, 0);
    @(negedge clk);
    req_vec = '0;
    rst_n = 1'b1;

    step('0, 0, 0, 0, 0, "R1 idle");
    step(17'h00018, 0, 0, 0, 0, "R2 rank 620 over 700");
    step('1, 1, 5, 5, 5, "R2 all lines, rank 0");
    step(17'h00006, 0, 0, 0, 0, "R2 rank 1 over 120");
    step(17'h004C0, 0, 0, 0, 0, "R3 tie 1110 user");
    step(17'h00480, 2, 0, 0, 0, "R3 tie 1110 hyper");
    step(17'h0F000, 0, 0, 3, 0, "R3 R5 window tie");
    step(17'h08000, 0, 0, 31, 0, "R5 fill other max index");
    step(17'h00800, 0, 9, 0, 0, "R5 interrupt level 9");
    step(17'h10000, 0, 0, 0, 127, "R5 trap number 127");
    step(17'h10800, 0, 15, 0, 0, "R4 1600 beats 1602");
    step(17'h00200, 1, 0, 0, 0, "R4 misaligned");
    step(17'h00010, 0, 0, 0, 0, "R6 priv opcode user");
    step(17'h00010, 1, 0, 0, 0, "R7 priv opcode priv");
    step(17'h00010, 2, 0, 0, 0, "R7 priv opcode hyper");
    step(17'h00010, 3, 0, 0, 0, "R7 level 3 as hyper");
    step(17'h00020, 2, 0, 0, 0, "R6 fp disabled hyper");
    step(17'h00020, 1, 0, 0, 0, "R6 fp disabled priv");
    step(17'h00400, 1, 0, 0, 0, "R7 priv action priv");
    step(17'h00400, 2, 0, 0, 0, "R7 priv action hyper");
    step(17'h00800, 1, 2, 0, 0, "R7 interrupt priv");
    step(17'h00800, 3, 2, 0, 0, "R7 interrupt level 3");
    step(17'h00040, 0, 0, 0, 0, "R9 base");
    step(17'h00040, 0, 15, 31, 127, "R9 foreign indices");
    step(17'h00100, 1, 7, 0, 0, "R9 div zero with level");
    step('0, 2, 3, 3, 3, "R1 idle again");

    for (int k = 0; k < 400; k++) begin
      logic [NL-1:0] r;
      r = NL'($urandom) & NL'($urandom);
      if (k % 5 == 0) r = '0;
      step(r, $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 31),
           $urandom_range(0, 127), "R2 R3 R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule